// File: doc/BRIEF.md
# 8-bit Arithmetic and Flag Unit

This block is the purely combinational execution stage of a small 8-bit processor core. The core presents an operation code, its accumulator, both index registers, the fetched operand byte and the current status byte. Within the same cycle the block returns three things: a result byte, a code naming the register the core should write it to, and the updated status byte. The core's sequencer owns all register state and memory traffic, and it commits the result and the status itself.

The flag rules follow the classic 8-bit convention. On subtraction and compare, the carry is an inverted borrow. Bit test copies the top two operand bits straight into the N and V flags. An extra operation ANDs the accumulator with X, subtracts the operand, and sends the difference to X. Status bits 2 to 5 (interrupt mask, decimal, break, unused) always pass through unchanged.

Top module: `alu8_flags`

## Requirements
- R1: Status layout is C=bit0, Z=bit1, V=bit6, N=bit7. Bits 2..5 of `st_out` always equal those of `st_in`. For every operation, Z is 1 exactly when `res` is 0, and N equals `res[7]` except for bit test.
- R2: Op 0 (add) gives `res` = low byte of acc+opnd+C. C is set to bit 8 of the 9-bit sum. V is set when acc and opnd have equal sign bits and `res` has a different one. `dst` = 1 (accumulator).
- R3: Op 1 (subtract) gives `res` = acc−opnd−(1−C). C is set to 1 when no borrow occurs. V is set to bit 7 of (acc^res)&(acc^opnd). `dst` = 1.
- R4: Ops 2, 3 and 4 compare acc, idx_x or idx_y (in that order) against opnd. `res` is the low byte of the difference. Z and N come from it, C=1 when there is no borrow, and V is unchanged. `dst` = 0 (no write).
- R5: Op 15 gives `res` = (acc AND idx_x) − opnd with `dst` = 2 (X). Z, N and C are set as for compare, and V is unchanged.
- R6: Op 8 (bit test) sets Z when acc AND opnd is 0, and copies opnd bit 7 into N and opnd bit 6 into V. C is unchanged. `res` = acc AND opnd and `dst` = 0.
- R7: Ops 5, 6 and 7 (AND, OR, XOR of acc with opnd) set only Z and N, leave C and V unchanged, and use `dst` = 1.
- R8: Op 11 shifts opnd left with the old bit 7 going to C. Op 12 shifts it right logically with the old bit 0 going to C, so N ends up 0. V is unchanged and `dst` = 3 (operand).
- R9: Op 13 rotates opnd left through C (old C to bit 0, old bit 7 to C). Op 14 rotates it right through C (old C to bit 7, old bit 0 to C). V is unchanged and `dst` = 3.
- R10: Ops 9 and 10 increment and decrement opnd modulo 256, update only Z and N, and use `dst` = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| acc | input | 8 | Accumulator |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| opnd | input | 8 | Operand byte |
| st_in | input | 8 | Current status byte |
| res | output | 8 | Result byte |
| dst | output | 2 | Write target: 0 none, 1 accumulator, 2 X, 3 operand |
| st_out | output | 8 | Updated status byte |

## Verification
The hardest case to reach is the one where both the overflow rule and the borrow rule fire: signed overflow on subtract-with-borrow when the carry-in is clear, and an (A AND X) difference that wraps below zero. Only particular sign and magnitude pairs produce these. The stimulus therefore sweeps every operation over all 256×256 operand pairs with both carry-in values. Index registers and the pass-through status bits are derived from the operands, so those bits vary across the sweep as well. Hand-computed directed vectors come first and pin each boundary case.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] idx_x,
  input  logic [W-1:0] idx_y,
  input  logic [W-1:0] opnd,
  input  logic [7:0]   st_in,
  output logic [W-1:0] res,
  output logic [1:0]   dst,
  output logic [7:0]   st_out
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CPA = 4'd2, OP_CPX = 4'd3,
                         OP_CPY = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_BIT = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_SHL = 4'd11,
                         OP_SHR = 4'd12, OP_ROL = 4'd13, OP_ROR = 4'd14, OP_AXS = 4'd15;
  localparam logic [1:0] D_NONE = 2'd0, D_ACC = 2'd1, D_X = 2'd2, D_MEM = 2'd3;
  localparam int MSB = W - 1;

  logic         cin;
  logic [W:0]   add_s, sub_s, cmp_s;
  logic [W-1:0] cmp_lhs;
  logic         c_n, v_n;

  assign cin   = st_in[0];
  assign add_s = {1'b0, acc} + {1'b0, opnd} + {{W{1'b0}}, cin};
  assign sub_s = {1'b0, acc} - {1'b0, opnd} - {{W{1'b0}}, ~cin};

  always_comb begin
    case (op_sel)
      OP_CPX:  cmp_lhs = idx_x;
      OP_CPY:  cmp_lhs = idx_y;
      OP_AXS:  cmp_lhs = acc & idx_x;
      default: cmp_lhs = acc;
    endcase
  end
  assign cmp_s = {1'b0, cmp_lhs} - {1'b0, opnd};

  always_comb begin
    res = '0;
    dst = D_NONE;
    c_n = cin;
    v_n = st_in[6];
    case (op_sel)
      OP_ADD: begin
        res = add_s[W-1:0];
        dst = D_ACC;
        c_n = add_s[W];
        v_n = ~(acc[MSB] ^ opnd[MSB]) & (acc[MSB] ^ add_s[MSB]);
      end
      OP_SUB: begin
        res = sub_s[W-1:0];
        dst = D_ACC;
        c_n = ~sub_s[W];
        v_n = (acc[MSB] ^ sub_s[MSB]) & (acc[MSB] ^ opnd[MSB]);
      end
      OP_CPA, OP_CPX, OP_CPY: begin
        res = cmp_s[W-1:0];
        c_n = ~cmp_s[W];
      end
      OP_AXS: begin
        res = cmp_s[W-1:0];
        dst = D_X;
        c_n = ~cmp_s[W];
      end
      OP_AND: begin res = acc & opnd; dst = D_ACC; end
      OP_OR:  begin res = acc | opnd; dst = D_ACC; end
      OP_XOR: begin res = acc ^ opnd; dst = D_ACC; end
      OP_BIT: begin
        res = acc & opnd;
        v_n = opnd[MSB-1];
      end
      OP_INC: begin res = opnd + 1'b1; dst = D_MEM; end
      OP_DEC: begin res = opnd - 1'b1; dst = D_MEM; end
      OP_SHL: begin res = {opnd[W-2:0], 1'b0}; dst = D_MEM; c_n = opnd[MSB]; end
      OP_SHR: begin res = {1'b0, opnd[W-1:1]}; dst = D_MEM; c_n = opnd[0]; end
      OP_ROL: begin res = {opnd[W-2:0], cin};  dst = D_MEM; c_n = opnd[MSB]; end
      OP_ROR: begin res = {cin, opnd[W-1:1]};  dst = D_MEM; c_n = opnd[0]; end
      default: ;
    endcase
  end

  assign st_out = {(op_sel == OP_BIT) ? opnd[MSB] : res[MSB], v_n, st_in[5:2], res == '0, c_n};
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic [3:0] op_sel,
  input logic [7:0] acc,
  input logic [7:0] idx_x,
  input logic [7:0] idx_y,
  input logic [7:0] opnd,
  input logic [7:0] st_in,
  input logic [7:0] res,
  input logic [1:0] dst,
  input logic [7:0] st_out
);
  always_comb begin
    assert_passthru_R1: assert (st_out[5:2] == st_in[5:2]) else $error("R1 bits 2..5 altered");
    assert_zero_flag_R1: assert (st_out[1] == (res == 8'h00)) else $error("R1 Z mismatch");
    if (op_sel != 4'd8)
      assert_neg_flag_R1: assert (st_out[7] == res[7]) else $error("R1 N mismatch");
    if (op_sel >= 4'd2 && op_sel <= 4'd4)
      assert_cmp_nowrite_R4: assert (dst == 2'd0 && st_out[6] == st_in[6]) else $error("R4 compare wrote");
    if (op_sel == 4'd15)
      assert_axs_to_x_R5: assert (dst == 2'd2 && st_out[6] == st_in[6]) else $error("R5 target");
    if (op_sel == 4'd8)
      assert_bit_copy_R6: assert (st_out[7:6] == opnd[7:6] && st_out[0] == st_in[0] && dst == 2'd0)
        else $error("R6 bit test flags");
    if (op_sel >= 4'd5 && op_sel <= 4'd7)
      assert_logic_keep_R7: assert (st_out[0] == st_in[0] && st_out[6] == st_in[6]) else $error("R7 C/V changed");
    if (op_sel == 4'd12)
      assert_shr_neg_R8: assert (st_out[7] == 1'b0 && st_out[0] == opnd[0]) else $error("R8 shift right");
    if (op_sel == 4'd9 || op_sel == 4'd10)
      assert_incdec_keep_R10: assert (st_out[0] == st_in[0] && st_out[6] == st_in[6] && dst == 2'd3)
        else $error("R10 inc/dec flags");
  end
endmodule

bind alu8_flags alu8_flags_chk u_alu8_flags_chk (
  .op_sel(op_sel), .acc(acc), .idx_x(idx_x), .idx_y(idx_y), .opnd(opnd),
  .st_in(st_in), .res(res), .dst(dst), .st_out(st_out)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/10ps
module test_alu8_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] op_sel;
  logic [7:0] acc, idx_x, idx_y, opnd, st_in, res, st_out;
  logic [1:0] dst;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  alu8_flags i_alu8_flags (.op_sel(op_sel), .acc(acc), .idx_x(idx_x), .idx_y(idx_y),
                           .opnd(opnd), .st_in(st_in), .res(res), .dst(dst), .st_out(st_out));

  // op, acc, x, y, opnd, st_in, exp res, exp dst, exp st
  localparam int NV = 22;
  localparam logic [61:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h00, 8'h00, 8'h50, 8'h00, 8'hA0, 2'd1, 8'hC0}, // R2 overflow
    {4'd0,  8'hFF, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 2'd1, 8'h01}, // R2 carry in+out
    {4'd0,  8'hFF, 8'h00, 8'h00, 8'h01, 8'h24, 8'h00, 2'd1, 8'h27}, // R2 R1 zero, passthru
    {4'd1,  8'h50, 8'h00, 8'h00, 8'hF0, 8'h01, 8'h60, 2'd1, 8'h00}, // R3 borrow
    {4'd1,  8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h7F, 2'd1, 8'h41}, // R3 overflow
    {4'd1,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 2'd1, 8'h80}, // R3 borrow-in
    {4'd2,  8'h40, 8'h00, 8'h00, 8'h40, 8'h40, 8'h00, 2'd0, 8'h43}, // R4 equal, V kept
    {4'd3,  8'h00, 8'h10, 8'h00, 8'h20, 8'h01, 8'hF0, 2'd0, 8'h80}, // R4 X below
    {4'd4,  8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 2'd0, 8'h81}, // R4 Y above
    {4'd15, 8'hF0, 8'h3C, 8'h00, 8'h10, 8'h00, 8'h20, 2'd2, 8'h01}, // R5 no borrow
    {4'd15, 8'h0F, 8'hF0, 8'h00, 8'h01, 8'h00, 8'hFF, 2'd2, 8'h80}, // R5 wrap
    {4'd8,  8'h01, 8'h00, 8'h00, 8'hC0, 8'h00, 8'h00, 2'd0, 8'hC2}, // R6
    {4'd5,  8'hF0, 8'h00, 8'h00, 8'h0F, 8'hC1, 8'h00, 2'd1, 8'h43}, // R7 and
    {4'd6,  8'h80, 8'h00, 8'h00, 8'h01, 8'h02, 8'h81, 2'd1, 8'h80}, // R7 or
    {4'd7,  8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 2'd1, 8'h02}, // R7 xor
    {4'd9,  8'h00, 8'h00, 8'h00, 8'hFF, 8'h01, 8'h00, 2'd3, 8'h03}, // R10 inc wrap
    {4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 2'd3, 8'h80}, // R10 dec wrap
    {4'd11, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00, 8'h02, 2'd3, 8'h01}, // R8 shl
    {4'd12, 8'h00, 8'h00, 8'h00, 8'h01, 8'h80, 8'h00, 2'd3, 8'h03}, // R8 shr
    {4'd13, 8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 2'd3, 8'h01}, // R9 rol
    {4'd14, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 2'd3, 8'h81}, // R9 ror
    {4'd14, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h01, 2'd3, 8'h00}  // R9 ror no carry
  };

  function automatic string req_of(input int op);
    case (op)
      0: return "R2"; 1: return "R3"; 2, 3, 4: return "R4"; 15: return "R5";
      8: return "R6"; 5, 6, 7: return "R7"; 11, 12: return "R8"; 13, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [17:0] model(input int op, input int a, input int x, input int y,
                                        input int m, input int s);
    int r = 0, d = 0, c = s & 1, v = (s >> 6) & 1, n, t;
    case (op)
      0: begin t = a + m + c; r = t & 255; c = t / 256; d = 1;
               v = ((a < 128) == (m < 128) && (a < 128) != (r < 128)) ? 1 : 0; end
      1: begin t = a - m - (1 - c); r = t & 255; c = (t >= 0) ? 1 : 0; d = 1;
               v = (((a ^ r) & (a ^ m)) >= 128) ? 1 : 0; end
      2, 3, 4, 15: begin
               t = (op == 2) ? a : (op == 3) ? x : (op == 4) ? y : (a & x);
               t = t - m; r = t & 255; c = (t >= 0) ? 1 : 0; d = (op == 15) ? 2 : 0; end
      5: begin r = a & m; d = 1; end
      6: begin r = a | m; d = 1; end
      7: begin r = a ^ m; d = 1; end
      8: begin r = a & m; v = (m >> 6) & 1; end
      9: begin r = (m + 1) % 256; d = 3; end
      10: begin r = (m + 255) % 256; d = 3; end
      11: begin r = (m * 2) % 256; c = m / 128; d = 3; end
      12: begin r = m / 2; c = m % 2; d = 3; end
      13: begin r = (m * 2) % 256 + c; c = m / 128; d = 3; end
      default: begin r = m / 2 + 128 * c; c = m % 2; d = 3; end
    endcase
    n = (op == 8) ? m / 128 : r / 128;
    t = n * 128 + v * 64 + (s & 8'h3C) + ((r == 0) ? 2 : 0) + c;
    return {r[7:0], d[1:0], t[7:0]};
  endfunction

  task automatic apply_chk(input logic [3:0] o, input logic [7:0] a, input logic [7:0] x,
                           input logic [7:0] y, input logic [7:0] m, input logic [7:0] s,
                           input logic [17:0] exp_v, input string rq);
    op_sel = o; acc = a; idx_x = x; idx_y = y; opnd = m; st_in = s;
    #0.2;
    n_chk++;
    if ({res, dst, st_out} !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h x=%h y=%h m=%h st=%h: got res=%h dst=%0d st=%h, expected res=%h dst=%0d st=%h",
               rq, o, a, x, y, m, s, res, dst, st_out, exp_v[17:10], exp_v[9:8], exp_v[7:0]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    op_sel = 0; acc = 0; idx_x = 0; idx_y = 0; opnd = 0; st_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 idle inputs: add of zeros gives zero, Z set, accumulator target
    apply_chk(4'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, {8'h00, 2'd1, 8'h02}, "R1");
    for (int i = 0; i < NV; i++)
      apply_chk(VEC[i][61:58], VEC[i][57:50], VEC[i][49:42], VEC[i][41:34], VEC[i][33:26],
                VEC[i][25:18], VEC[i][17:0], req_of(int'(VEC[i][61:58])));
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 256; m++)
          for (int c = 0; c < 2; c++) begin
            int x = a ^ 8'h5A;
            int y = (255 - a) ^ m;
            int s = ((a ^ m) & 8'hFE) | c;
            apply_chk(op[3:0], a[7:0], x[7:0], y[7:0], m[7:0], s[7:0],
                      model(op, a, x, y, m, s), req_of(op));
          end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule